// File: doc/BRIEF.md
# Paired Doubleword Load/Store Sequencer

This block executes one 128-bit memory instruction of a 64-bit core. The instruction word and the base register value come in together with a one-cycle `start` pulse. The block decodes the word and latches a scaled, sign-extended displacement added to the base. It then runs two 64-bit memory transactions back to back: the low doubleword first, then the high one at the address plus 8. A load delivers the two returned doublewords to two destination registers. A store reads two source registers and writes them out. Bit 15 of the word selects the integer or the floating-point register file.

The block is built around a seven-state controller. `S_IDLE` waits for `start`. From there, `start` leads to `S_EXC` (illegal word, or floating-point variant with the coprocessor disabled) or to `S_LO`. `S_LO` holds the first request until `mem_ready`, then moves to `S_HI`, or to `S_EXC` on `mem_err`. `S_HI` does the same for the second request. After it, a store goes to `S_FIN`, a load goes to `S_WLO`, and a fault goes to `S_EXC`. `S_WLO` writes the low doubleword and `S_WHI` writes the high one; then comes `S_FIN`. `S_FIN` and `S_EXC` each last one cycle, pulse `done`, and return to `S_IDLE`.

Top module: `pairmem_seq`

## Requirements
- R1: The word belongs to the group when insn[31:26] is 0x32 (load) or 0x3A (store) and insn[5] is 1. insn[15]=0 selects the integer file and insn[15]=1 the floating-point file. This is driven on `rd_fp` and `wr_fp`.
- R2: The first access address is `base` plus the signed 9-bit field insn[14:6] shifted left by 4. A field of 0x1FF gives -16.
- R3: The first request goes to the first address and the second to that address plus 8. The second is presented only after the first has been accepted.
- R4: On a load, the doubleword read from the lower address is written to register insn[20:16] and the one from the higher address to register insn[4:0].
- R5: On a store, register insn[20:16] is written to the lower address and register insn[4:0] to the higher address, with `mem_we`=1.
- R6: A floating-point variant issued while `cp1_usable`=0 ends with `exc_valid`=1 and `exc_code`=2. No memory request and no register write take place.
- R7: Any other word (wrong major opcode, or insn[5]=0) ends with `exc_valid`=1 and `exc_code`=1. No memory request and no register write take place.
- R8: Load register writes start only after both reads have been accepted. A `mem_err` on either access ends the operation with `exc_code`=3, and no register is written.
- R9: `busy` is high from the cycle after `start` through the cycle in which `done` is high. `done` is a single-cycle pulse.
- R10: While a request waits for `mem_ready`, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged.
- R11: After reset, `busy`, `done`, `mem_req`, `wr_en` and `exc_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an instruction (sampled in idle) |
| insn | input | 32 | Instruction word |
| base | input | 64 | Base register value |
| cp1_usable | input | 1 | Floating-point coprocessor enabled |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| exc_valid | output | 1 | Operation ended in an exception |
| exc_code | output | 2 | 1 reserved, 2 coprocessor unusable, 3 bus fault |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 64 | Request byte address |
| mem_wdata | output | 64 | Write data |
| mem_ready | input | 1 | Request accepted and completed this cycle |
| mem_rdata | input | 64 | Read data, valid with `mem_ready` |
| mem_err | input | 1 | Access fault, valid with `mem_ready` |
| rd_fp | output | 1 | Read port file select |
| rd_idx_a | output | 5 | First source register index |
| rd_idx_b | output | 5 | Second source register index |
| rd_data_a | input | 64 | First source data (combinational read) |
| rd_data_b | input | 64 | Second source data (combinational read) |
| wr_en | output | 1 | Register write enable |
| wr_fp | output | 1 | Write port file select |
| wr_idx | output | 5 | Destination register index |
| wr_data | output | 64 | Destination data |

## Verification
The bench builds the block with its default parameters: a 64-bit data path, a 9-bit displacement scaled by 16, and an 8-byte step. These defaults let a small memory model cover both positive and negative displacements, including the all-ones field. The memory model has a programmable acceptance delay, so the hold behaviour of a waiting request and the `busy` window can be observed. A selectable faulting address lets each of the two accesses fail on its own.

// File: rtl/pairmem_pkg.sv
package pairmem_pkg;

    localparam logic [5:0] OP_QLOAD  = 6'h32;
    localparam logic [5:0] OP_QSTORE = 6'h3A;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LO,
        S_HI,
        S_WLO,
        S_WHI,
        S_FIN,
        S_EXC
    } seq_state_t;

    typedef enum logic [1:0] {
        EXC_NONE = 2'd0,
        EXC_RSVD = 2'd1,
        EXC_COPU = 2'd2,
        EXC_BUS  = 2'd3
    } exc_t;

    typedef struct packed {
        logic       legal;
        logic       is_store;
        logic       fp;
        logic [4:0] reg_a;
        logic [4:0] reg_b;
    } dec_t;

endpackage

// File: rtl/pairmem_decode.sv
module pairmem_decode
    import pairmem_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int OFF_W   = 9,
    parameter int OFF_LSB = 6,
    parameter int SCALE   = 4
) (
    input  logic [31:0]     insn,
    input  logic [XLEN-1:0] base,
    output dec_t            dec,
    output logic [XLEN-1:0] ea
);
    localparam int EXT_W = XLEN - OFF_W;

    logic [5:0]       opc;
    logic [OFF_W-1:0] off_f;
    logic [XLEN-1:0]  off_x;
    logic             unused_base_field;

    assign opc               = insn[31:26];
    assign off_f             = insn[OFF_LSB +: OFF_W];
    assign unused_base_field = ^insn[25:21];

    always_comb begin
        dec.legal    = ((opc == OP_QLOAD) || (opc == OP_QSTORE)) && insn[5];
        dec.is_store = (opc == OP_QSTORE);
        dec.fp       = insn[15];
        dec.reg_a    = insn[20:16];
        dec.reg_b    = insn[4:0];
        off_x        = {{EXT_W{off_f[OFF_W-1]}}, off_f} << SCALE;
        ea           = base + off_x;
    end

endmodule

// File: rtl/pairmem_agen.sv
module pairmem_agen #(
    parameter int XLEN = 64,
    parameter int STEP = 8
) (
    input  logic [XLEN-1:0] ea,
    input  logic            second,
    output logic [XLEN-1:0] addr
);
    localparam logic [XLEN-1:0] STEP_X = XLEN'(STEP);

    assign addr = second ? (ea + STEP_X) : ea;

endmodule

// File: rtl/pairmem_seq.sv
module pairmem_seq
    import pairmem_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int RIDX  = 5,
    parameter int OFF_W = 9,
    parameter int SCALE = 4,
    parameter int STEP  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [31:0]     insn,
    input  logic [XLEN-1:0] base,
    input  logic            cp1_usable,
    output logic            busy,
    output logic            done,
    output logic            exc_valid,
    output logic [1:0]      exc_code,
    output logic            mem_req,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic            mem_ready,
    input  logic [XLEN-1:0] mem_rdata,
    input  logic            mem_err,
    output logic            rd_fp,
    output logic [RIDX-1:0] rd_idx_a,
    output logic [RIDX-1:0] rd_idx_b,
    input  logic [XLEN-1:0] rd_data_a,
    input  logic [XLEN-1:0] rd_data_b,
    output logic            wr_en,
    output logic            wr_fp,
    output logic [RIDX-1:0] wr_idx,
    output logic [XLEN-1:0] wr_data
);
    seq_state_t      state, nxt;
    dec_t            dec_w, dec_q;
    logic [XLEN-1:0] ea_w, ea_q;
    logic [XLEN-1:0] buf_lo, buf_hi;
    exc_t            exc_q;
    logic            accept;
    logic [XLEN-1:0] addr_w;

    pairmem_decode #(.XLEN(XLEN), .OFF_W(OFF_W), .OFF_LSB(6), .SCALE(SCALE)) u_dec (
        .insn (insn),
        .base (base),
        .dec  (dec_w),
        .ea   (ea_w)
    );

    pairmem_agen #(.XLEN(XLEN), .STEP(STEP)) u_agen (
        .ea     (ea_q),
        .second (state == S_HI),
        .addr   (addr_w)
    );

    assign accept = mem_req && mem_ready;

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (start) begin
                if (!dec_w.legal)                    nxt = S_EXC;
                else if (dec_w.fp && !cp1_usable)    nxt = S_EXC;
                else                                 nxt = S_LO;
            end
            S_LO:   if (mem_ready) nxt = mem_err ? S_EXC : S_HI;
            S_HI:   if (mem_ready) begin
                if (mem_err)             nxt = S_EXC;
                else if (dec_q.is_store) nxt = S_FIN;
                else                     nxt = S_WLO;
            end
            S_WLO:  nxt = S_WHI;
            S_WHI:  nxt = S_FIN;
            S_FIN:  nxt = S_IDLE;
            S_EXC:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // instruction latch, read buffers, exception cause
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q  <= '0;
            ea_q   <= '0;
            buf_lo <= '0;
            buf_hi <= '0;
            exc_q  <= EXC_NONE;
        end else begin
            if (state == S_IDLE && start) begin
                dec_q <= dec_w;
                ea_q  <= ea_w;
                if (!dec_w.legal)                 exc_q <= EXC_RSVD;
                else if (dec_w.fp && !cp1_usable) exc_q <= EXC_COPU;
                else                              exc_q <= EXC_NONE;
            end
            if (accept && mem_err) exc_q <= EXC_BUS;
            if (accept && state == S_LO) buf_lo <= mem_rdata;
            if (accept && state == S_HI) buf_hi <= mem_rdata;
        end
    end

    // outputs
    always_comb begin
        busy      = (state != S_IDLE);
        done      = 1'b0;
        exc_valid = 1'b0;
        exc_code  = exc_q;
        mem_req   = 1'b0;
        mem_we    = dec_q.is_store;
        mem_addr  = addr_w;
        mem_wdata = rd_data_a;
        rd_fp     = dec_q.fp;
        rd_idx_a  = dec_q.reg_a;
        rd_idx_b  = dec_q.reg_b;
        wr_en     = 1'b0;
        wr_fp     = dec_q.fp;
        wr_idx    = dec_q.reg_a;
        wr_data   = buf_lo;
        unique case (state)
            S_IDLE: ;
            S_LO:   mem_req = 1'b1;
            S_HI: begin
                mem_req   = 1'b1;
                mem_wdata = rd_data_b;
            end
            S_WLO:  wr_en = 1'b1;
            S_WHI: begin
                wr_en   = 1'b1;
                wr_idx  = dec_q.reg_b;
                wr_data = buf_hi;
            end
            S_FIN:  done = 1'b1;
            S_EXC: begin
                done      = 1'b1;
                exc_valid = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pairmem_chk.sv
module pairmem_chk #(
    parameter int XLEN = 64,
    parameter int STEP = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            done,
    input logic            exc_valid,
    input logic            mem_req,
    input logic            mem_ready,
    input logic            mem_err,
    input logic            mem_we,
    input logic [XLEN-1:0] mem_addr,
    input logic [XLEN-1:0] mem_wdata,
    input logic            wr_en
);
    localparam logic [XLEN-1:0] STEP_X = XLEN'(STEP);

    a_r9_req_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || wr_en || done) |-> busy);

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                     && $stable(mem_wdata)));

    a_r3_second_plus_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && !mem_err) |=> (!mem_req || mem_addr == $past(mem_addr) + STEP_X));

    a_r8_no_write_during_access: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !mem_req);

    a_r8_fault_ends_op: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && mem_err) |=> (exc_valid && !wr_en && !mem_req));

    a_r7_exc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (done && !mem_req && !wr_en));

endmodule

bind pairmem_seq pairmem_chk #(.XLEN(XLEN), .STEP(STEP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .exc_valid (exc_valid),
    .mem_req   (mem_req),
    .mem_ready (mem_ready),
    .mem_err   (mem_err),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .wr_en     (wr_en)
);

// File: tb/pairmem_seq_tb.sv
module pairmem_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] insn = '0;
    logic [63:0] base = '0;
    logic        cp1_usable = 1'b1;
    logic        busy, done, exc_valid, mem_req, mem_we, mem_ready, mem_err;
    logic [1:0]  exc_code;
    logic [63:0] mem_addr, mem_wdata, mem_rdata, rd_data_a, rd_data_b, wr_data;
    logic        rd_fp, wr_en, wr_fp;
    logic [4:0]  rd_idx_a, rd_idx_b, wr_idx;

    logic [63:0] memory [64];
    logic [63:0] gpr [32];
    logic [63:0] fpr [32];
    logic [63:0] tr_addr [4];
    int          n_acc, n_wr, early_wr, lat, lat_cnt;
    logic        fault_en = 1'b0;
    logic [63:0] fault_addr = '0;
    int          checks = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pairmem_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .insn(insn), .base(base),
        .cp1_usable(cp1_usable), .busy(busy), .done(done), .exc_valid(exc_valid),
        .exc_code(exc_code), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .mem_err(mem_err), .rd_fp(rd_fp), .rd_idx_a(rd_idx_a), .rd_idx_b(rd_idx_b),
        .rd_data_a(rd_data_a), .rd_data_b(rd_data_b), .wr_en(wr_en), .wr_fp(wr_fp),
        .wr_idx(wr_idx), .wr_data(wr_data)
    );

    assign mem_ready = mem_req && (lat_cnt >= lat);
    assign mem_rdata = memory[mem_addr[8:3]];
    assign mem_err   = fault_en && (mem_addr == fault_addr);
    assign rd_data_a = rd_fp ? fpr[rd_idx_a] : gpr[rd_idx_a];
    assign rd_data_b = rd_fp ? fpr[rd_idx_b] : gpr[rd_idx_b];

    always @(posedge clk) begin
        if (mem_req && !mem_ready) lat_cnt <= lat_cnt + 1;
        else                       lat_cnt <= 0;
        if (mem_req && mem_ready) begin
            if (n_acc < 4) tr_addr[n_acc] <= mem_addr;
            n_acc <= n_acc + 1;
            if (mem_we && !mem_err) memory[mem_addr[8:3]] <= mem_wdata;
        end
        if (wr_en) begin
            n_wr <= n_wr + 1;
            if (n_acc < 2) early_wr <= early_wr + 1;
            if (wr_fp) fpr[wr_idx] <= wr_data;
            else       gpr[wr_idx] <= wr_data;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] ra,
                                       input logic fp, input logic [8:0] off,
                                       input logic sel, input logic [4:0] rb);
        return {op, 5'd0, ra, fp, off, sel, rb};
    endfunction

    // issues one instruction and waits for done; returns exception info
    task automatic run(input logic [31:0] w, input logic [63:0] b,
                       output logic ev, output logic [1:0] ec, output int gaps);
        int cyc;
        @(negedge clk);
        n_acc = 0; n_wr = 0; early_wr = 0; gaps = 0;
        insn = w; base = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 200) begin
            if (!busy) gaps++;
            @(negedge clk);
            cyc++;
        end
        chk(done, "R9 done reached", 64'(done), 64'd1);
        chk(busy, "R9 busy with done", 64'(busy), 64'd1);
        ev = exc_valid; ec = exc_code;
        @(negedge clk);
        chk(!done && !busy, "R9 single done pulse", {62'd0, done, busy}, 64'd0);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !mem_req && !wr_en && !exc_valid, "R11 reset state",
            {59'd0, busy, done, mem_req, wr_en, exc_valid}, 64'd0);
    endtask

    task automatic t_int_load();
        logic ev; logic [1:0] ec; int g;
        logic [63:0] e_lo, e_hi;
        e_lo = memory[6'h24]; e_hi = memory[6'h25];
        run(mk(6'h32, 5'd3, 1'b0, 9'd2, 1'b1, 5'd7), 64'h100, ev, ec, g);
        chk(!ev, "R1 int load no exception", 64'(ev), 64'd0);
        chk(n_acc == 2 && tr_addr[0] == 64'h120, "R2 first address", tr_addr[0], 64'h120);
        chk(tr_addr[1] == 64'h128, "R3 second address", tr_addr[1], 64'h128);
        chk(gpr[3] == e_lo, "R4 low to rt", gpr[3], e_lo);
        chk(gpr[7] == e_hi, "R4 high to second reg", gpr[7], e_hi);
        chk(fpr[3] == 64'hF003, "R1 fp file untouched", fpr[3], 64'hF003);
        chk(early_wr == 0, "R8 writes after both reads", 64'(early_wr), 64'd0);
    endtask

    task automatic t_fp_load_neg();
        logic ev; logic [1:0] ec; int g;
        logic [63:0] e_lo, e_hi;
        e_lo = memory[6'h0E]; e_hi = memory[6'h0F];
        run(mk(6'h32, 5'd10, 1'b1, 9'h1FF, 1'b1, 5'd11), 64'h80, ev, ec, g);
        chk(tr_addr[0] == 64'h70, "R2 negative offset", tr_addr[0], 64'h70);
        chk(tr_addr[1] == 64'h78, "R3 negative second", tr_addr[1], 64'h78);
        chk(fpr[10] == e_lo && fpr[11] == e_hi, "R4 fp destinations", fpr[10], e_lo);
        chk(gpr[10] == 64'hA00A, "R1 int file untouched", gpr[10], 64'hA00A);
    endtask

    task automatic t_int_store();
        logic ev; logic [1:0] ec; int g;
        run(mk(6'h3A, 5'd4, 1'b0, 9'd1, 1'b1, 5'd9), 64'h40, ev, ec, g);
        chk(memory[6'h0A] == 64'hA004, "R5 rt to low", memory[6'h0A], 64'hA004);
        chk(memory[6'h0B] == 64'hA009, "R5 second reg to high", memory[6'h0B], 64'hA009);
        chk(n_wr == 0, "R5 store writes no register", 64'(n_wr), 64'd0);
    endtask

    task automatic t_fp_store();
        logic ev; logic [1:0] ec; int g;
        run(mk(6'h3A, 5'd20, 1'b1, 9'h1FE, 1'b1, 5'd21), 64'h180, ev, ec, g);
        chk(!ev && memory[6'h2C] == 64'hF014, "R5 fp store low", memory[6'h2C], 64'hF014);
        chk(memory[6'h2D] == 64'hF015, "R5 fp store high", memory[6'h2D], 64'hF015);
    endtask

    task automatic t_cop_unusable();
        logic ev; logic [1:0] ec; int g;
        cp1_usable = 1'b0;
        run(mk(6'h32, 5'd12, 1'b1, 9'd0, 1'b1, 5'd13), 64'h0, ev, ec, g);
        cp1_usable = 1'b1;
        chk(ev && ec == 2'd2, "R6 coprocessor exception", {62'd0, ec}, 64'd2);
        chk(n_acc == 0 && n_wr == 0, "R6 no access", 64'(n_acc + n_wr), 64'd0);
    endtask

    task automatic t_illegal();
        logic ev; logic [1:0] ec; int g;
        run(mk(6'h32, 5'd3, 1'b0, 9'd0, 1'b0, 5'd7), 64'h0, ev, ec, g);
        chk(ev && ec == 2'd1, "R7 bit5 clear reserved", {62'd0, ec}, 64'd1);
        chk(n_acc == 0 && n_wr == 0, "R7 no access", 64'(n_acc + n_wr), 64'd0);
        run(mk(6'h23, 5'd3, 1'b0, 9'd0, 1'b1, 5'd7), 64'h0, ev, ec, g);
        chk(ev && ec == 2'd1, "R7 foreign opcode reserved", {62'd0, ec}, 64'd1);
    endtask

    task automatic t_fault();
        logic ev; logic [1:0] ec; int g;
        fault_en = 1'b1; fault_addr = 64'h108;
        run(mk(6'h32, 5'd5, 1'b0, 9'd0, 1'b1, 5'd6), 64'h100, ev, ec, g);
        chk(ev && ec == 2'd3, "R8 fault on second", {62'd0, ec}, 64'd3);
        chk(n_wr == 0 && gpr[5] == 64'hA005, "R8 no register written", gpr[5], 64'hA005);
        fault_addr = 64'h100;
        run(mk(6'h32, 5'd5, 1'b0, 9'd0, 1'b1, 5'd6), 64'h100, ev, ec, g);
        chk(ev && ec == 2'd3 && n_acc == 1, "R8 fault on first", 64'(n_acc), 64'd1);
        fault_en = 1'b0;
    endtask

    task automatic t_latency();
        logic ev; logic [1:0] ec; int g;
        logic [63:0] e_lo;
        e_lo = memory[6'h30];
        lat = 3;
        run(mk(6'h32, 5'd14, 1'b0, 9'd0, 1'b1, 5'd15), 64'h180, ev, ec, g);
        lat = 0;
        chk(g == 0, "R9 busy held throughout", 64'(g), 64'd0);
        chk(n_acc == 2 && gpr[14] == e_lo, "R10 slow memory load", gpr[14], e_lo);
        chk(tr_addr[1] == 64'h188, "R3 order under wait", tr_addr[1], 64'h188);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) memory[i] = {32'hC0DE0000, 32'(i)};
        for (int i = 0; i < 32; i++) begin
            gpr[i] = 64'hA000 + 64'(i);
            fpr[i] = 64'hF000 + 64'(i);
        end
        n_acc = 0; n_wr = 0; early_wr = 0; lat = 0; lat_cnt = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_int_load();
        t_fp_load_neg();
        t_int_store();
        t_fp_store();
        t_cop_unusable();
        t_illegal();
        t_fault();
        t_latency();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule